// File: doc/BRIEF.md
# Port Command Slot Scheduler

This block sits inside one port of a serial storage host controller. It holds the port's run controls (start and frame-receive enable), the register where software posts command slots, and the tracking registers for queued (tagged) commands. Each clock cycle it may offer one posted slot to a downstream command engine. The engine answers in the same cycle in one of three ways: it finished the slot, it took the slot but stays busy, or it deferred the slot.

Queued completions arrive as tag pulses. Each pulse clears that tag's active bit at once and adds the tag to a finished mask. A read of the active register also removes the finished tags, and then empties the mask. The first time frame reception is switched on after a reset, the block asks once for an initial device-to-host status frame.

Top module: `slot_dispatch_port`

## Requirements
- R1: After reset, every readable register reads zero, no slot is offered, the finished mask is zero and no status-frame request is raised.
- R2: Register select 0 is the control register. Bit 0 is start and bit 4 is frame-receive enable, and both are stored from a write. Bit 15 (list running) and bit 14 (frame-receive running) always read back as copies of start and enable. Values written to bits 15 and 14 are ignored.
- R3: A control write with bit 4 set, made while no status frame has been requested since the last reset or port reset, raises `init_frame_req` for exactly one cycle, in the cycle after the write. Later such writes raise nothing.
- R4: A write to register select 1 (the issue register) ORs the written bits into it. A write never clears a bit.
- R5: A slot is offered only while start is 1, the issue register is nonzero, `eng_busy` is 0 and no busy slot is recorded.
- R6: The offered slot is the lowest posted slot at or above the scan position. The scan position returns to 0 after every done or busy answer and after every completion. Answer code 1 (done) clears that slot's issue bit at the same edge.
- R7: Answer code 0 (defer), or the unused code 3, moves the scan position to the next higher slot. If no posted slot lies at or above the scan position, no slot is offered in that cycle and the position returns to 0.
- R8: Answer code 2 (busy) records the slot and blocks further offers. The recorded slot's issue bit is cleared at the first edge where `eng_busy` is 0.
- R9: A queued completion on `q_tag` clears that bit in the active register (select 2) and sets it in `q_finished`. If `q_fail` is also 1, it sets the same bit in the error register (select 3).
- R10: A write to the active register ORs bits in. A write to the error register clears the bits written as 1. A read of the active register returns active AND NOT finished, stores that value back and zeroes the finished mask at the same edge.
- R11: `port_rst` clears the issue register, the busy-slot record, the finished mask and the frame-requested flag. The control, active and error registers keep their values.
- R12: Every offered slot is a posted slot, and each offer receives exactly one answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_rst | input | 1 | Synchronous port reset pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on select 2) |
| reg_sel | input | 2 | Register select: 0 control, 1 issue, 2 active, 3 error |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register, combinational |
| eng_busy | input | 1 | Engine status shows busy or data-request |
| disp_valid | output | 1 | A slot is offered this cycle |
| disp_slot | output | SLOT_W | Offered slot number |
| disp_resp | input | 2 | Same-cycle answer: 0 defer, 1 done, 2 busy, 3 treated as defer |
| q_done | input | 1 | Queued-tag completion pulse |
| q_tag | input | SLOT_W | Completed tag |
| q_fail | input | 1 | The completion reports an error |
| q_finished | output | SLOTS | Tags finished since the last active-register read |
| init_frame_req | output | 1 | One-cycle request for the initial status frame |

## Verification
A scan position that is off by one shows up in the very next offer. A deferred slot would be offered again, or a higher posted slot would be skipped, and either shows as a wrong `disp_slot` within one cycle. A busy record that is lost or kept too long shows as an offer made while the engine is busy, or as an issue bit that is still set one cycle after `eng_busy` drops. A wrong finished mask only becomes visible when the active register is read, so the checks read that register just before and just after a completion lands.

// File: rtl/sds_pkg.sv
package sds_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_ISSUE = 2'd1,
    SEL_QACT  = 2'd2,
    SEL_QERR  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    RESP_DEFER = 2'd0,
    RESP_DONE  = 2'd1,
    RESP_BUSY  = 2'd2,
    RESP_RSVD  = 2'd3
  } disp_resp_e;

  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_FRE_BIT   = 4;
  localparam int CTRL_FRR_BIT   = 14;
  localparam int CTRL_LRUN_BIT  = 15;

  // Control readback: running flags mirror their enables.
  function automatic logic [31:0] ctrl_view(input logic start, input logic fre);
    logic [31:0] v;
    v = '0;
    v[CTRL_START_BIT] = start;
    v[CTRL_FRE_BIT]   = fre;
    v[CTRL_FRR_BIT]   = fre;
    v[CTRL_LRUN_BIT]  = start;
    return v;
  endfunction

endpackage

// File: rtl/sds_ctrl_reg.sv
module sds_ctrl_reg
  import sds_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        port_rst,
  input  logic        wr_ctrl,
  input  logic        wr_start,
  input  logic        wr_fre,
  output logic        start,
  output logic        fre,
  output logic        init_req,
  output logic [31:0] ctrl_rd
);

  logic sent_q;
  logic frame_fire;

  assign frame_fire = wr_ctrl && wr_fre && !sent_q && !port_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start    <= 1'b0;
      fre      <= 1'b0;
      sent_q   <= 1'b0;
      init_req <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        start <= wr_start;
        fre   <= wr_fre;
      end
      init_req <= frame_fire;
      if (port_rst)        sent_q <= 1'b0;
      else if (frame_fire) sent_q <= 1'b1;
    end
  end

  assign ctrl_rd = ctrl_view(start, fre);

endmodule

// File: rtl/sds_issue_sched.sv
module sds_issue_sched
  import sds_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_rst,
  input  logic              start,
  input  logic              eng_busy,
  input  logic              wr_issue,
  input  logic [SLOTS-1:0]  wbits,
  input  logic [1:0]        resp,
  input  logic              q_event,
  output logic [SLOTS-1:0]  issue,
  output logic              disp_valid,
  output logic [SLOT_W-1:0] disp_slot,
  output logic              busy_valid,
  output logic              done_fire,
  output logic              busy_fire,
  output logic              busy_clear
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  // Lowest set bit at or above base; MSB of result flags a hit.
  function automatic logic [SLOT_W:0] pick_from(input logic [SLOTS-1:0] v,
                                                input logic [SLOT_W-1:0] base);
    logic [SLOT_W:0] r;
    r = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (v[i] && (i >= int'(base))) r = {1'b1, SLOT_W'(i)};
    end
    return r;
  endfunction

  function automatic logic [SLOTS-1:0] one_bit(input logic [SLOT_W-1:0] idx);
    logic [SLOTS-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction

  logic [SLOT_W-1:0] scan_q;
  logic [SLOT_W-1:0] busy_idx;
  logic [SLOT_W:0]   pick;
  logic              can_run;
  logic              defer_fire;
  logic [SLOTS-1:0]  clr_vec;

  assign pick       = pick_from(issue, scan_q);
  assign can_run    = start && (|issue) && !eng_busy && !busy_valid;
  assign disp_valid = can_run && pick[SLOT_W];
  assign disp_slot  = pick[SLOT_W-1:0];
  assign done_fire  = disp_valid && (resp == RESP_DONE);
  assign busy_fire  = disp_valid && (resp == RESP_BUSY);
  assign defer_fire = disp_valid && !done_fire && !busy_fire;
  assign busy_clear = busy_valid && !eng_busy;

  always_comb begin
    clr_vec = '0;
    if (done_fire)  clr_vec = one_bit(disp_slot);
    if (busy_clear) clr_vec = one_bit(busy_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue      <= '0;
      scan_q     <= '0;
      busy_valid <= 1'b0;
      busy_idx   <= '0;
    end else if (port_rst) begin
      issue      <= '0;
      scan_q     <= '0;
      busy_valid <= 1'b0;
      busy_idx   <= '0;
    end else begin
      issue <= (issue & ~clr_vec) | (wr_issue ? wbits : '0);
      if (busy_fire) begin
        busy_valid <= 1'b1;
        busy_idx   <= disp_slot;
      end else if (busy_clear) begin
        busy_valid <= 1'b0;
      end
      if (done_fire || busy_fire || busy_clear || q_event || !pick[SLOT_W])
        scan_q <= '0;
      else if (defer_fire)
        scan_q <= (disp_slot == LAST_SLOT) ? '0 : disp_slot + 1'b1;
    end
  end

endmodule

// File: rtl/sds_queue_track.sv
module sds_queue_track #(
  parameter int SLOTS  = 32,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_rst,
  input  logic              wr_act,
  input  logic              wr_err,
  input  logic              rd_act,
  input  logic [SLOTS-1:0]  wbits,
  input  logic              q_done,
  input  logic [SLOT_W-1:0] q_tag,
  input  logic              q_fail,
  output logic [SLOTS-1:0]  active,
  output logic [SLOTS-1:0]  errs,
  output logic [SLOTS-1:0]  finished,
  output logic [SLOTS-1:0]  act_view
);

  logic [SLOTS-1:0] tag_bit;

  always_comb begin
    tag_bit = '0;
    if (q_done) tag_bit[q_tag] = 1'b1;
  end

  assign act_view = active & ~finished;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= '0;
      errs     <= '0;
      finished <= '0;
    end else begin
      active   <= ((rd_act ? act_view : active) & ~tag_bit) | (wr_act ? wbits : '0);
      errs     <= (errs & ~(wr_err ? wbits : '0)) | (q_fail ? tag_bit : '0);
      finished <= port_rst ? '0 : ((rd_act ? '0 : finished) | tag_bit);
    end
  end

endmodule

// File: rtl/slot_dispatch_port.sv
module slot_dispatch_port
  import sds_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              eng_busy,
  output logic              disp_valid,
  output logic [SLOT_W-1:0] disp_slot,
  input  logic [1:0]        disp_resp,
  input  logic              q_done,
  input  logic [SLOT_W-1:0] q_tag,
  input  logic              q_fail,
  output logic [SLOTS-1:0]  q_finished,
  output logic              init_frame_req
);

  logic             wr_ctrl, wr_issue, wr_act, wr_err, rd_act;
  logic             start, fre;
  logic [31:0]      ctrl_rd;
  logic [SLOTS-1:0] issue, active, errs, act_view;
  logic             busy_valid, done_fire, busy_fire, busy_clear;

  assign wr_ctrl  = reg_wr && (reg_sel == SEL_CTRL);
  assign wr_issue = reg_wr && (reg_sel == SEL_ISSUE);
  assign wr_act   = reg_wr && (reg_sel == SEL_QACT);
  assign wr_err   = reg_wr && (reg_sel == SEL_QERR);
  assign rd_act   = reg_rd && (reg_sel == SEL_QACT);

  sds_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .port_rst(port_rst),
    .wr_ctrl(wr_ctrl),
    .wr_start(reg_wdata[CTRL_START_BIT]), .wr_fre(reg_wdata[CTRL_FRE_BIT]),
    .start(start), .fre(fre), .init_req(init_frame_req), .ctrl_rd(ctrl_rd)
  );

  sds_issue_sched #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .port_rst(port_rst),
    .start(start), .eng_busy(eng_busy),
    .wr_issue(wr_issue), .wbits(reg_wdata[SLOTS-1:0]),
    .resp(disp_resp), .q_event(q_done),
    .issue(issue), .disp_valid(disp_valid), .disp_slot(disp_slot),
    .busy_valid(busy_valid), .done_fire(done_fire),
    .busy_fire(busy_fire), .busy_clear(busy_clear)
  );

  sds_queue_track #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .port_rst(port_rst),
    .wr_act(wr_act), .wr_err(wr_err), .rd_act(rd_act),
    .wbits(reg_wdata[SLOTS-1:0]),
    .q_done(q_done), .q_tag(q_tag), .q_fail(q_fail),
    .active(active), .errs(errs), .finished(q_finished), .act_view(act_view)
  );

  always_comb begin
    unique case (reg_sel)
      SEL_CTRL:  reg_rdata = ctrl_rd;
      SEL_ISSUE: reg_rdata = 32'(issue);
      SEL_QACT:  reg_rdata = 32'(act_view);
      default:   reg_rdata = 32'(errs);
    endcase
  end

endmodule

// File: rtl/sds_checker.sv
module sds_checker #(
  parameter int SLOTS  = 32,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              port_rst,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic [31:0]       reg_wdata,
  input logic              eng_busy,
  input logic              disp_valid,
  input logic [SLOT_W-1:0] disp_slot,
  input logic [1:0]        disp_resp,
  input logic              q_done,
  input logic [SLOT_W-1:0] q_tag,
  input logic              init_frame_req,
  input logic              start,
  input logic              busy_valid,
  input logic [SLOTS-1:0]  issue,
  input logic [SLOTS-1:0]  active,
  input logic [SLOTS-1:0]  q_finished
);

  p_offer_issued_r12: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> issue[disp_slot]);

  p_offer_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (start && !eng_busy && !busy_valid));

  p_init_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    init_frame_req |=> !init_frame_req);

  p_issue_or_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd1 && !port_rst)
      |=> ((issue & $past(reg_wdata[SLOTS-1:0])) == $past(reg_wdata[SLOTS-1:0])));

  p_done_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_resp == 2'd1 && !port_rst && !(reg_wr && reg_sel == 2'd1))
      |=> !issue[$past(disp_slot)]);

  p_busy_record_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_resp == 2'd2 && !port_rst) |=> busy_valid);

  p_qdone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_done && !port_rst && !(reg_wr && reg_sel == 2'd2))
      |=> (!active[$past(q_tag)] && q_finished[$past(q_tag)]));

  p_port_rst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    port_rst |=> (issue == '0 && !busy_valid && q_finished == '0));

endmodule

bind slot_dispatch_port sds_checker #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_sds_chk (
  .clk(clk), .rst_n(rst_n), .port_rst(port_rst),
  .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .eng_busy(eng_busy), .disp_valid(disp_valid), .disp_slot(disp_slot),
  .disp_resp(disp_resp), .q_done(q_done), .q_tag(q_tag),
  .init_frame_req(init_frame_req), .start(start), .busy_valid(busy_valid),
  .issue(issue), .active(active), .q_finished(q_finished)
);

// File: tb/test_slot_dispatch_port.sv
module test_slot_dispatch_port;

  localparam int SLOTS  = 32;
  localparam int SLOT_W = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              port_rst = 1'b0;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]        reg_sel = 2'd0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              eng_busy = 1'b0;
  logic              disp_valid;
  logic [SLOT_W-1:0] disp_slot;
  logic [1:0]        disp_resp;
  logic              q_done = 1'b0, q_fail = 1'b0;
  logic [SLOT_W-1:0] q_tag = '0;
  logic [SLOTS-1:0]  q_finished;
  logic              init_frame_req;

  logic [1:0] resp_tbl [SLOTS];
  assign disp_resp = resp_tbl[disp_slot];

  int checks = 0;
  int failures = 0;
  int expq[$];

  always #2 clk = ~clk;

  slot_dispatch_port #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) i_slot_dispatch_port (
    .clk(clk), .rst_n(rst_n), .port_rst(port_rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_busy(eng_busy), .disp_valid(disp_valid), .disp_slot(disp_slot),
    .disp_resp(disp_resp), .q_done(q_done), .q_tag(q_tag), .q_fail(q_fail),
    .q_finished(q_finished), .init_frame_req(init_frame_req)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk_rd(input logic [1:0] sel, input logic [31:0] exp, input string req);
    logic [31:0] d;
    reg_sel = sel; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(req, d, exp);
  endtask

  task automatic qdone(input logic [SLOT_W-1:0] tag, input logic fail);
    q_tag = tag; q_fail = fail; q_done = 1'b1;
    @(negedge clk);
    q_done = 1'b0; q_fail = 1'b0;
  endtask

  // Scoreboard monitor: every offer must match the next expected slot (R12).
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && disp_valid) begin
        checks++;
        if (expq.size() == 0) begin
          failures++;
          $display("FAIL R12 offer got=%0d exp=none", disp_slot);
        end else begin
          int e;
          e = expq.pop_front();
          if (int'(disp_slot) != e) begin
            failures++;
            $display("FAIL R6 offer got=%0d exp=%0d", disp_slot, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < SLOTS; i++) resp_tbl[i] = 2'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_rd(2'd0, 32'h0, "R1 ctrl");
    chk_rd(2'd1, 32'h0, "R1 issue");
    chk_rd(2'd2, 32'h0, "R1 active");
    chk_rd(2'd3, 32'h0, "R1 error");
    chk("R1 offer", 32'(disp_valid), 32'h0);
    chk("R1 req", 32'(init_frame_req), 32'h0);
    chk("R1 finished", q_finished, 32'h0);

    // R2 running bits are not writable; R3 frame request
    wr(2'd0, 32'h0000_C000);
    chk("R3 no req", 32'(init_frame_req), 32'h0);
    chk_rd(2'd0, 32'h0, "R2 running ignored");
    wr(2'd0, 32'h0000_0010);
    chk("R3 req pulse", 32'(init_frame_req), 32'h1);
    @(negedge clk);
    chk("R3 req one cycle", 32'(init_frame_req), 32'h0);
    chk_rd(2'd0, 32'h0000_4010, "R2 derived fre running");
    wr(2'd0, 32'h0000_0010);
    chk("R3 only once", 32'(init_frame_req), 32'h0);

    // R4 OR-only issue writes; R5 no offer with start off
    wr(2'd1, 32'h0000_0005);
    wr(2'd1, 32'h0000_0100);
    chk_rd(2'd1, 32'h0000_0105, "R4 or");
    wr(2'd1, 32'h0);
    chk_rd(2'd1, 32'h0000_0105, "R4 no clear");
    chk("R5 start off", 32'(disp_valid), 32'h0);

    // R5 engine busy blocks, then R6 ordered dispatch
    eng_busy = 1'b1;
    wr(2'd0, 32'h0000_0011);
    chk_rd(2'd0, 32'h0000_C011, "R2 both running");
    repeat (2) @(negedge clk);
    chk("R5 engine busy", 32'(disp_valid), 32'h0);
    expq.push_back(0); expq.push_back(2); expq.push_back(8);
    eng_busy = 1'b0;
    repeat (4) @(negedge clk);
    chk_rd(2'd1, 32'h0, "R6 done clears");
    wr(2'd0, 32'h0000_0010);

    // R7 defer moves scan upward
    resp_tbl[1] = 2'd0; resp_tbl[3] = 2'd1;
    wr(2'd1, 32'h0000_000A);
    expq.push_back(1); expq.push_back(3); expq.push_back(1);
    wr(2'd0, 32'h0000_0011);
    @(negedge clk);
    @(negedge clk);
    wr(2'd0, 32'h0000_0010);
    chk_rd(2'd1, 32'h0000_0002, "R7 deferred kept");
    // R7 wrap with gap cycle
    expq.push_back(1); expq.push_back(1);
    wr(2'd0, 32'h0000_0011);
    @(negedge clk);
    #1 chk("R7 gap", 32'(disp_valid), 32'h0);
    @(negedge clk);
    wr(2'd0, 32'h0000_0010);
    resp_tbl[1] = 2'd1;
    expq.push_back(1);
    wr(2'd0, 32'h0000_0011);
    wr(2'd0, 32'h0000_0010);
    chk_rd(2'd1, 32'h0, "R6 slot1 done");

    // R8 busy slot
    resp_tbl[4] = 2'd2; resp_tbl[6] = 2'd1;
    wr(2'd1, 32'h0000_0050);
    expq.push_back(4);
    wr(2'd0, 32'h0000_0011);
    @(negedge clk);
    eng_busy = 1'b1;
    repeat (3) @(negedge clk);
    chk_rd(2'd1, 32'h0000_0050, "R8 held while busy");
    expq.push_back(6);
    eng_busy = 1'b0;
    @(negedge clk);
    chk_rd(2'd1, 32'h0000_0040, "R8 cleared on idle");
    chk_rd(2'd1, 32'h0, "R6 after busy");
    wr(2'd0, 32'h0000_0010);

    // R9 / R10 queued tracking
    wr(2'd2, 32'h0000_0011);
    chk_rd(2'd2, 32'h0000_0011, "R10 active or");
    qdone(5'd4, 1'b0);
    chk("R9 finished", q_finished, 32'h0000_0010);
    chk_rd(2'd2, 32'h0000_0001, "R9 active cleared");
    chk("R10 finished zeroed", q_finished, 32'h0);
    qdone(5'd0, 1'b1);
    chk_rd(2'd3, 32'h0000_0001, "R9 error set");
    chk_rd(2'd2, 32'h0, "R9 active tag0");
    wr(2'd3, 32'h0000_0001);
    chk_rd(2'd3, 32'h0, "R10 error w1c");
    qdone(5'd2, 1'b0);
    wr(2'd2, 32'h0000_0004);
    chk_rd(2'd2, 32'h0, "R10 lazy mask");
    chk("R10 mask emptied", q_finished, 32'h0);
    wr(2'd2, 32'h0000_0004);
    chk_rd(2'd2, 32'h0000_0004, "R10 rewrite");

    // R11 port reset
    wr(2'd1, 32'h0000_0003);
    qdone(5'd5, 1'b0);
    port_rst = 1'b1;
    @(negedge clk);
    port_rst = 1'b0;
    chk_rd(2'd1, 32'h0, "R11 issue");
    chk("R11 finished", q_finished, 32'h0);
    chk_rd(2'd0, 32'h0000_4010, "R11 ctrl kept");
    chk_rd(2'd2, 32'h0000_0004, "R11 active kept");
    wr(2'd0, 32'h0000_0010);
    chk("R11 req again", 32'(init_frame_req), 32'h1);
    @(negedge clk);
    chk("R3 req drops", 32'(init_frame_req), 32'h0);
    // R11 busy record dropped
    resp_tbl[7] = 2'd2; resp_tbl[0] = 2'd1;
    wr(2'd1, 32'h0000_0080);
    expq.push_back(7);
    wr(2'd0, 32'h0000_0011);
    @(negedge clk);
    eng_busy = 1'b1; port_rst = 1'b1;
    @(negedge clk);
    port_rst = 1'b0;
    wr(2'd1, 32'h0000_0001);
    expq.push_back(0);
    eng_busy = 1'b0;
    repeat (2) @(negedge clk);
    chk_rd(2'd1, 32'h0, "R11 busy cleared");
    wr(2'd0, 32'h0000_0010);

    repeat (2) @(negedge clk);
    chk("R12 all offers seen", 32'(expq.size()), 32'h0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule